// File: doc/BRIEF.md
# Dual-Width Local Register Port

This block is a slave register port on the local side of a bridge. A small bank of eight 32-bit registers is reached over a shared tristate data bus. An active-low select strobe qualifies the 5-bit word address and the active-low read and write strobes. Writes are captured on the rising clock edge. Reads drive the bus combinationally while the strobes are held.

A static mode pin sets the bus to 32 or 16 bits wide. In 32-bit mode four active-low byte enables pick lanes. In 16-bit mode only bus bits 15:0 carry data, and the top enable pin instead chooses which half of the register is accessed. The pass-through data register ignores the mode pin. Its usable lanes are set by a region-size input. A separate active-low pin places the full pass-through address register on the bus at any time.

Top module: `lbus_regport`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero.
- R2: While `sel_n` is high, writes do not change any register and the design drives no bus lane.
- R3: In 32-bit mode (`narrow`=0), a write updates byte lane k (bits 8k+7:8k) only when its active-low enable is low. `be_n[0..2]` map to lanes 0..2, and `be3_hsel` maps to lane 3.
- R4: In 32-bit mode, a read drives a lane only when its enable is low, and that lane carries the register byte.
- R5: In 16-bit mode (`narrow`=1), a read drives only bus lanes 0 and 1, gated by `be_n[0]` and `be_n[1]`. `be3_hsel`=1 returns register bits 31:16, and 0 returns bits 15:0. `be_n[2]` is ignored.
- R6: In 16-bit mode, a write places bus bits 15:0 into the half picked by `be3_hsel`, byte by byte under `be_n[1:0]`. The other half is unchanged.
- R7: The pass-through data register (word address 0x0B) is always accessed at 32-bit width, whatever `narrow` is.
- R8: For the pass-through data register, `region_sz` 0 allows lane 0 only, 1 allows lanes 0–1, and 2 or 3 allows all lanes. Disallowed lanes read as zero and ignore writes.
- R9: While `ptaddr_n` is low and no write is in progress, all 32 bus bits carry the pass-through address register (word address 0x0A), in either width mode.
- R10: A word address outside the map reads as zero on the enabled lanes, and a write to it changes no register.
- R11: If read and write strobes are low together, the write is performed and the design does not drive the bus.
- R12: Word addresses 0x03, 0x07, 0x0A, 0x0B, 0x0D, 0x0E, 0x0F and 0x10 hold eight independent registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are captured on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low select qualifying address and strobes |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| waddr | input | 5 | Word address (byte address bits 6:2) |
| be_n | input | 3 | Active-low byte enables for lanes 0..2 |
| be3_hsel | input | 1 | Lane 3 enable (32-bit) or half select (16-bit) |
| narrow | input | 1 | Width mode: 0 = 32-bit bus, 1 = 16-bit bus |
| region_sz | input | 2 | Pass-through data width: 0 = 8, 1 = 16, else 32 bits |
| ptaddr_n | input | 1 | Active-low direct output of the pass-through address |
| dq | inout | 32 | Tristate data bus |

## Verification
The assertions assume that the width mode and region size are held steady for the whole of each access, and that the master drives the bus only while the write strobe is low. The bench changes its inputs only on falling edges. It drives `dq` only inside write cycles and releases the bus before any read. Lanes the design leaves undriven are pulled high in the bench. For that reason every read pattern avoids an all-ones byte, so an undriven lane can be told apart from a driven one.

// File: rtl/lbus_regport.sv
module lbus_regport (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_n,
  input  logic        wr_n,
  input  logic        rd_n,
  input  logic [4:0]  waddr,
  input  logic [2:0]  be_n,
  input  logic        be3_hsel,
  input  logic        narrow,
  input  logic [1:0]  region_sz,
  input  logic        ptaddr_n,
  inout  wire  [31:0] dq
);
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;
  localparam int HW    = DW / 2;
  localparam int NREG  = 8;
  localparam int PTA_IDX = 2;
  localparam int PTD_IDX = 3;
  localparam logic [4:0] A_MBIN = 5'h03, A_MBOUT = 5'h07, A_PTA = 5'h0A, A_PTD = 5'h0B,
                         A_MBST = 5'h0D, A_ICTL  = 5'h0E, A_RCTL = 5'h0F, A_CFG = 5'h10;

  logic [NREG-1:0][DW-1:0] bank;
  logic [2:0] idx;
  logic       hit;

  always_comb begin
    hit = 1'b1;
    idx = 3'd0;
    case (waddr)
      A_MBIN:  idx = 3'd0;
      A_MBOUT: idx = 3'd1;
      A_PTA:   idx = 3'(PTA_IDX);
      A_PTD:   idx = 3'(PTD_IDX);
      A_MBST:  idx = 3'd4;
      A_ICTL:  idx = 3'd5;
      A_RCTL:  idx = 3'd6;
      A_CFG:   idx = 3'd7;
      default: hit = 1'b0;
    endcase
  end

  wire wr_on  = !sel_n && !wr_n;
  wire rd_on  = !sel_n && !rd_n && wr_n;
  wire pt_on  = !ptaddr_n && !wr_on;
  wire is_ptd = (waddr == A_PTD);
  wire full   = !narrow || is_ptd;

  logic [LANES-1:0] rgn_ok;
  always_comb begin
    case (region_sz)
      2'd0:    rgn_ok = 4'b0001;
      2'd1:    rgn_ok = 4'b0011;
      default: rgn_ok = 4'b1111;
    endcase
  end

  wire [LANES-1:0] lane_ok  = is_ptd ? rgn_ok : {LANES{1'b1}};
  wire [LANES-1:0] be_on    = ~{be3_hsel, be_n};
  wire [LANES-1:0] half_on  = be3_hsel ? {~be_n[1:0], 2'b00} : {2'b00, ~be_n[1:0]};
  wire [LANES-1:0] wr_lanes = full ? (be_on & lane_ok) : half_on;
  wire [LANES-1:0] rd_lanes = full ? be_on : {2'b00, ~be_n[1:0]};
  wire [DW-1:0]    wdata    = full ? dq : {dq[HW-1:0], dq[HW-1:0]};
  wire [DW-1:0]    cur      = hit ? bank[idx] : '0;

  logic [DW-1:0] ok_mask;
  logic [DW-1:0] dout;
  logic [LANES-1:0] drv_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ok_mask[8*g +: 8] = {8{lane_ok[g]}};
    assign dq[8*g +: 8]      = drv_en[g] ? dout[8*g +: 8] : 8'hzz;
  end

  wire [DW-1:0] rdata = full ? (cur & ok_mask)
                             : {{HW{1'b0}}, be3_hsel ? cur[DW-1:HW] : cur[HW-1:0]};

  assign drv_en = pt_on ? {LANES{1'b1}} : (rd_on ? rd_lanes : '0);
  assign dout   = pt_on ? bank[PTA_IDX] : rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank <= '0;
    end else if (wr_on && hit) begin
      for (int l = 0; l < LANES; l++)
        if (wr_lanes[l]) bank[idx][8*l +: 8] <= wdata[8*l +: 8];
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> bank == '0); // R1
  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> $stable(bank)); // R2
  AST_NARROW_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && ptaddr_n && waddr != A_PTD) |-> drv_en[3:2] == 2'b00); // R5
  AST_REGION_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_on && is_ptd && region_sz == 2'd0) |=> $stable(bank[PTD_IDX][DW-1:8])); // R8
  AST_PTA_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptaddr_n && !(!sel_n && !wr_n)) |-> dq == bank[PTA_IDX]); // R9
  AST_UNMAPPED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_on && !hit) |=> $stable(bank)); // R10
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wr_n && ptaddr_n) |-> drv_en == '0); // R11
endmodule

// File: tb/lbus_regport_test.sv
module lbus_regport_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, ptaddr_n = 1'b1;
  logic [4:0] waddr = '0;
  logic [2:0] be_n = 3'b111;
  logic be3_hsel = 1'b1, narrow = 1'b0;
  logic [1:0] region_sz = 2'd2;
  logic [31:0] tb_dq = '0;
  logic tb_oe = 1'b0;
  wire [31:0] dq;

  assign dq = tb_oe ? tb_dq : 32'hzzzz_zzzz;
  for (genvar g = 0; g < 32; g++) begin : g_pu
    pullup (dq[g]);
  end

  lbus_regport uut (.clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
    .waddr(waddr), .be_n(be_n), .be3_hsel(be3_hsel), .narrow(narrow),
    .region_sz(region_sz), .ptaddr_n(ptaddr_n), .dq(dq));

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [31:0] mdl [8];
  logic [4:0] amap [8] = '{5'h03, 5'h07, 5'h0A, 5'h0B, 5'h0D, 5'h0E, 5'h0F, 5'h10};

  function automatic int idx_of(input logic [4:0] a);
    for (int i = 0; i < 8; i++) if (amap[i] == a) return i;
    return -1;
  endfunction

  function automatic int rgn_lanes(input logic [1:0] rs);
    return rs == 2'd0 ? 1 : (rs == 2'd1 ? 2 : 4);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] a, input logic [3:0] b,
                                         input logic nar, input logic [1:0] rs);
    int i = idx_of(a);
    logic [31:0] v = (i < 0) ? 32'h0 : mdl[i];
    logic [31:0] r = 32'hFFFF_FFFF;
    logic [15:0] h;
    if (!nar || a == 5'h0B) begin
      for (int l = 0; l < 4; l++)
        if (!b[l]) r[8*l +: 8] = (a != 5'h0B || l < rgn_lanes(rs)) ? v[8*l +: 8] : 8'h00;
    end else begin
      h = b[3] ? v[31:16] : v[15:0];
      for (int l = 0; l < 2; l++) if (!b[l]) r[8*l +: 8] = h[8*l +: 8];
    end
    return r;
  endfunction

  task automatic mdl_wr(input logic [4:0] a, input logic [3:0] b, input logic nar,
                        input logic [1:0] rs, input logic [31:0] d);
    int i = idx_of(a);
    int hl;
    if (i < 0) return;
    if (!nar || a == 5'h0B) begin
      for (int l = 0; l < 4; l++)
        if (!b[l] && (a != 5'h0B || l < rgn_lanes(rs))) mdl[i][8*l +: 8] = d[8*l +: 8];
    end else begin
      hl = b[3] ? 2 : 0;
      for (int k = 0; k < 2; k++) if (!b[k]) mdl[i][8*(hl+k) +: 8] = d[8*k +: 8];
    end
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] b, input logic nar,
                    input logic [1:0] rs, input logic [31:0] d, input logic seln = 1'b0);
    @(negedge clk);
    waddr = a; {be3_hsel, be_n} = b; narrow = nar; region_sz = rs;
    tb_dq = d; tb_oe = 1'b1; sel_n = seln; wr_n = 1'b0;
    @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1; tb_oe = 1'b0;
    if (!seln) mdl_wr(a, b, nar, rs, d);
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [3:0] b,
                    input logic nar, input logic [1:0] rs);
    @(negedge clk);
    waddr = a; {be3_hsel, be_n} = b; narrow = nar; region_sz = rs;
    sel_n = 1'b0; rd_n = 1'b0;
    #5 chk(req, dq, exp_rd(a, b, nar, rs));
    sel_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) rd("R1 reset value", amap[i], 4'h0, 1'b0, 2'd2);
    #2 chk("R2 idle bus undriven", dq, 32'hFFFF_FFFF);

    for (int i = 0; i < 8; i++) wr(amap[i], 4'h0, 1'b0, 2'd2, 32'h0102_0304 + i * 32'h1010_1010);
    for (int i = 0; i < 8; i++) rd("R12 independent registers", amap[i], 4'h0, 1'b0, 2'd2);

    for (int b = 0; b < 16; b++) begin
      wr(5'h03, 4'h0, 1'b0, 2'd2, 32'h1122_3344);
      wr(5'h03, 4'(b), 1'b0, 2'd2, 32'hA1B2_C3D4 ^ {4{4'h0, 4'(b)}});
      rd("R3 lane-gated write", 5'h03, 4'h0, 1'b0, 2'd2);
      rd("R4 lane-gated read", 5'h03, 4'(b), 1'b0, 2'd2);
    end

    for (int hs = 0; hs < 2; hs++)
      for (int e = 0; e < 8; e++) begin
        wr(5'h0E, 4'h0, 1'b0, 2'd2, 32'h2468_1357);
        wr(5'h0E, {1'(hs), 3'(e)}, 1'b1, 2'd2, {16'h3C3C, 16'h5A00 + 16'(e * 16 + hs)});
        rd("R6 half-word write", 5'h0E, 4'h0, 1'b0, 2'd2);
        for (int r = 0; r < 8; r++)
          rd("R5 half-word read", 5'h0E, {1'(hs), 3'(r)}, 1'b1, 2'd2);
      end

    wr(5'h0B, 4'h0, 1'b1, 2'd2, 32'h4C5D_6E70);
    rd("R7 pass-through data full width", 5'h0B, 4'h0, 1'b1, 2'd2);
    rd("R7 pass-through data lane gated", 5'h0B, 4'b0101, 1'b1, 2'd2);

    for (int rs = 0; rs < 4; rs++) begin
      wr(5'h0B, 4'h0, 1'b0, 2'd2, 32'h0000_0000);
      wr(5'h0B, 4'h0, 1'b0, 2'(rs), 32'h7E6D_5C4B);
      rd("R8 region-limited write", 5'h0B, 4'h0, 1'b0, 2'd2);
      wr(5'h0B, 4'h0, 1'b0, 2'd2, 32'h1A2B_3C4D);
      rd("R8 region-limited read", 5'h0B, 4'h0, 1'b1, 2'(rs));
    end

    wr(5'h0A, 4'h0, 1'b0, 2'd2, 32'h6172_8394);
    @(negedge clk);
    narrow = 1'b1; ptaddr_n = 1'b0;
    #5 chk("R9 direct address output, idle", dq, mdl[2]);
    @(negedge clk);
    waddr = 5'h03; {be3_hsel, be_n} = 4'h0; sel_n = 1'b0; rd_n = 1'b0;
    #5 chk("R9 direct address output over read", dq, mdl[2]);
    sel_n = 1'b1; rd_n = 1'b1; ptaddr_n = 1'b1; narrow = 1'b0;

    for (int a = 0; a < 32; a++)
      if (idx_of(5'(a)) < 0) begin
        wr(5'(a), 4'h0, 1'b0, 2'd2, 32'hDEAD_BEEF);
        rd("R10 unmapped reads zero", 5'(a), 4'h0, 1'b0, 2'd2);
      end
    for (int i = 0; i < 8; i++) rd("R10 mapped registers untouched", amap[i], 4'h0, 1'b0, 2'd2);

    @(negedge clk);
    waddr = 5'h0D; {be3_hsel, be_n} = 4'h0; narrow = 1'b0;
    tb_dq = 32'h3344_5566; tb_oe = 1'b1; sel_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; tb_oe = 1'b0;
    mdl_wr(5'h0D, 4'h0, 1'b0, 2'd2, 32'h3344_5566);
    rd("R11 write wins over read", 5'h0D, 4'h0, 1'b0, 2'd2);

    wr(5'h0F, 4'h0, 1'b0, 2'd2, 32'h7071_7273, 1'b1);
    rd("R2 unselected write ignored", 5'h0F, 4'h0, 1'b0, 2'd2);
    @(negedge clk);
    waddr = 5'h0F; {be3_hsel, be_n} = 4'h0; sel_n = 1'b1; rd_n = 1'b0;
    #5 chk("R2 unselected read undriven", dq, 32'hFFFF_FFFF);
    rd_n = 1'b1;

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    for (int i = 0; i < 8; i++) rd("R1 reset after use", amap[i], 4'h0, 1'b0, 2'd2);

    finish_run();
  end
endmodule